// File: doc/BRIEF.md
# Supply-Noise-Aware Flit Acceptance Throttler

This per-router controller decides, every cycle, which input channels may accept a flit. It limits the number that do so, because simultaneous buffer writes draw current all at once. A region-level supply budget arrives as an input. It caps the number of accept enables raised in a cycle, even when more channels have free buffer space. In the congestion-aware mode, the channel with the least buffer occupancy is always served first. Any remaining budget is handed out in rotating order, so no channel is starved for many cycles in a row. In the congestion-agnostic mode, occupancy is ignored and the rotating order alone decides.

The same block also picks the output direction for the flit at the head of the router. Two minimal directions are given: a preferred one and an orthogonal one. The block is told whether the neighbour in each direction is currently accepting. A throttled preferred neighbour causes a reroute to the orthogonal minimal direction. If both are throttled, the flit keeps its preferred direction and waits.

Top module: `flit_accept_throttle`

## Requirements
- R1: An accept enable is never raised for a channel whose buffer-space flag is 0.
- R2: The number of raised accept enables is the smaller of the budget input and the number of channels with buffer space. Budget values above the channel count behave as the channel count.
- R3: In congestion-aware mode (`cong_mode`=1), with a budget of at least 1, the channel with buffer space and the lowest occupancy is always enabled. Occupancy ties go to the lowest channel index.
- R4: A rotation pointer resets to channel 0 and advances by one channel every clock cycle, wrapping after the last channel. Enables beyond the guaranteed one go to channels with space in increasing index order, starting at the pointer.
- R5: In congestion-agnostic mode (`cong_mode`=0), enables go only by the rotation order of R4, regardless of occupancy.
- R6: When `pref_ok`=1, `out_dir` equals `pref_dir` and `out_wait`=0.
- R7: When `pref_ok`=0, `alt_valid`=1 and `alt_ok`=1, `out_dir` equals `alt_dir` and `out_wait`=0.
- R8: When `pref_ok`=0 and the orthogonal direction is unusable, `out_dir` equals `pref_dir` and `out_wait`=1. Unusable means `alt_valid`=0 or `alt_ok`=0.
- R9: When the destination lies along one axis (`alt_valid`=0), `out_dir` never takes `alt_dir`.
- R10: While reset is asserted, the rotation pointer is at channel 0, and the enables follow R1 to R5 with that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cong_mode | input | 1 | 1 = congestion-aware, 0 = congestion-agnostic |
| space_ok | input | NCH | Per-channel flag: buffer can take a flit |
| occ_flat | input | NCH*OW | Per-channel occupancy, channel i at bits i*OW +: OW |
| budget | input | BW | Allowed number of simultaneous accepts |
| pref_dir | input | 2 | Preferred minimal output direction |
| alt_dir | input | 2 | Orthogonal minimal output direction |
| alt_valid | input | 1 | An orthogonal minimal direction exists |
| pref_ok | input | 1 | Preferred neighbour is accepting |
| alt_ok | input | 1 | Orthogonal neighbour is accepting |
| accept_en | output | NCH | Per-channel accept enables |
| out_dir | output | 2 | Chosen output direction |
| out_wait | output | 1 | Flit holds its direction and waits this cycle |

## Verification
The bench builds the block with its defaults: four channels, 3-bit occupancy and a 3-bit budget. With these, the budget can exceed the channel count, and every pointer position is reached within four cycles. The vectors place the lowest-occupancy channel both on and off the pointer, force occupancy ties, and leave full channels inside the rotation window. This separates the guarantee, the rotation and the space mask. Each case of the route choice is driven in both modes, including the single-axis case where no reroute exists.

// File: rtl/flit_accept_throttle.sv
module flit_accept_throttle #(
  parameter int NCH = 4,
  parameter int OW  = 3,
  parameter int BW  = $clog2(NCH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cong_mode,
  input  logic [NCH-1:0]  space_ok,
  input  logic [NCH*OW-1:0] occ_flat,
  input  logic [BW-1:0]   budget,
  input  logic [1:0]      pref_dir,
  input  logic [1:0]      alt_dir,
  input  logic            alt_valid,
  input  logic            pref_ok,
  input  logic            alt_ok,
  output logic [NCH-1:0]  accept_en,
  output logic [1:0]      out_dir,
  output logic            out_wait
);
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] best;
  logic          best_ok;
  logic [OW-1:0] best_occ;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ptr <= '0;
    else if (ptr == PW'(NCH - 1)) ptr <= '0;
    else ptr <= ptr + 1'b1;

  always_comb begin
    best     = '0;
    best_ok  = 1'b0;
    best_occ = '1;
    for (int i = 0; i < NCH; i++) begin
      if (space_ok[i] && (!best_ok || occ_flat[i*OW +: OW] < best_occ)) begin
        best     = PW'(i);
        best_occ = occ_flat[i*OW +: OW];
        best_ok  = 1'b1;
      end
    end
  end

  always_comb begin
    int left;
    logic [PW-1:0] idx;
    accept_en = '0;
    left = int'(budget);
    if (cong_mode && best_ok && left > 0) begin
      accept_en[best] = 1'b1;
      left = left - 1;
    end
    for (int k = 0; k < NCH; k++) begin
      idx = PW'((int'(ptr) + k) % NCH);
      if (space_ok[idx] && !accept_en[idx] && left > 0) begin
        accept_en[idx] = 1'b1;
        left = left - 1;
      end
    end
  end

  wire use_alt = !pref_ok && alt_valid && alt_ok;
  assign out_dir  = use_alt ? alt_dir : pref_dir;
  assign out_wait = !pref_ok && !use_alt;
endmodule

module flit_accept_throttle_chk #(
  parameter int NCH = 4,
  parameter int PW  = 2,
  parameter int BW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] space_ok,
  input logic [BW-1:0]  budget,
  input logic [NCH-1:0] accept_en,
  input logic [PW-1:0]  ptr,
  input logic [1:0]     pref_dir,
  input logic [1:0]     alt_dir,
  input logic           alt_valid,
  input logic           pref_ok,
  input logic           alt_ok,
  input logic [1:0]     out_dir,
  input logic           out_wait
);
  // R1
  no_full_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_en & ~space_ok) == '0);
  // R2
  budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(accept_en) <= int'(budget));
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |->
      ptr == (($past(ptr) == PW'(NCH - 1)) ? '0 : $past(ptr) + 1'b1));
  // R6
  pref_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pref_ok |-> (out_dir == pref_dir && !out_wait));
  // R7
  reroute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pref_ok && alt_valid && alt_ok) |-> (out_dir == alt_dir && !out_wait));
  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wait |-> (out_dir == pref_dir && !pref_ok));
  // R9
  single_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_valid && !pref_ok) |-> out_wait);
endmodule

bind flit_accept_throttle flit_accept_throttle_chk #(.NCH(NCH), .PW(PW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .space_ok(space_ok), .budget(budget),
  .accept_en(accept_en), .ptr(ptr), .pref_dir(pref_dir), .alt_dir(alt_dir),
  .alt_valid(alt_valid), .pref_ok(pref_ok), .alt_ok(alt_ok),
  .out_dir(out_dir), .out_wait(out_wait)
);

// File: tb/sim_flit_accept_throttle.sv
module sim_flit_accept_throttle;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cong_mode;
  logic [3:0]  space_ok;
  logic [11:0] occ_flat;
  logic [2:0]  budget;
  logic [1:0]  pref_dir = 2'd1;
  logic [1:0]  alt_dir = 2'd3;
  logic        alt_valid, pref_ok, alt_ok;
  logic [3:0]  accept_en;
  logic [1:0]  out_dir;
  logic        out_wait;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flit_accept_throttle u0 (
    .clk(clk), .rst_n(rst_n), .cong_mode(cong_mode), .space_ok(space_ok),
    .occ_flat(occ_flat), .budget(budget), .pref_dir(pref_dir), .alt_dir(alt_dir),
    .alt_valid(alt_valid), .pref_ok(pref_ok), .alt_ok(alt_ok),
    .accept_en(accept_en), .out_dir(out_dir), .out_wait(out_wait)
  );

  // {mode, space[4], occ{o3,o2,o1,o0}[12], budget[3], pref_ok, alt_valid, alt_ok, exp_grant[4], exp_alt, exp_wait}
  function automatic logic [28:0] mkv(input logic m, input logic [3:0] s,
      input logic [2:0] o3, o2, o1, o0, input logic [2:0] b,
      input logic p, av, ao, input logic [3:0] g, input logic ea, ew);
    return {m, s, o3, o2, o1, o0, b, p, av, ao, g, ea, ew};
  endfunction

  localparam logic [28:0] VEC [NV] = '{
    mkv(1, 4'b1111, 2, 7, 2, 5, 2, 1, 1, 1, 4'b0011, 0, 0), // R3 tie->ch1, R4 ptr0, R6
    mkv(1, 4'b1111, 2, 7, 2, 5, 2, 0, 1, 1, 4'b0110, 1, 0), // R4 ptr1 skips guaranteed, R7
    mkv(1, 4'b1101, 2, 7, 2, 5, 3, 0, 1, 0, 4'b1101, 0, 1), // R1 full ch1, R8
    mkv(0, 4'b1111, 2, 7, 2, 5, 2, 0, 0, 1, 4'b1001, 0, 1), // R5 ptr3, R9
    mkv(0, 4'b1010, 0, 0, 0, 0, 4, 1, 1, 1, 4'b1010, 0, 0), // R2 budget>space
    mkv(1, 4'b1111, 0, 0, 0, 0, 0, 1, 0, 0, 4'b0000, 0, 0), // R2 budget 0
    mkv(1, 4'b0000, 0, 0, 0, 0, 4, 0, 1, 1, 4'b0000, 1, 0), // R1 none free, R7
    mkv(1, 4'b1111, 0, 0, 0, 0, 1, 0, 0, 0, 4'b0001, 0, 1), // R3 tie beats ptr3, R8
    mkv(1, 4'b1111, 7, 0, 7, 7, 1, 1, 1, 0, 4'b0100, 0, 0), // R3 off-pointer, R6
    mkv(0, 4'b1111, 7, 7, 7, 0, 1, 0, 1, 1, 4'b0010, 1, 0), // R5 occ ignored, R7
    mkv(1, 4'b1111, 4, 4, 4, 1, 4, 1, 0, 1, 4'b1111, 0, 0), // R2 all granted
    mkv(1, 4'b0111, 0, 1, 3, 3, 2, 0, 1, 0, 4'b0101, 0, 1)  // R1/R4 wrap past full ch3, R8
  };

  task automatic chk_grant(input string tag, input logic [3:0] exp);
    n_tests++;
    if (accept_en !== exp) begin
      n_fail++;
      $display("FAIL %s accept_en=%b expected=%b", tag, accept_en, exp);
    end
  endtask

  task automatic chk_route(input string tag, input logic [1:0] ed, input logic ew);
    n_tests++;
    if (out_dir !== ed || out_wait !== ew) begin
      n_fail++;
      $display("FAIL %s dir=%0d wait=%b expected dir=%0d wait=%b",
               tag, out_dir, out_wait, ed, ew);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10: reset state, pointer at channel 0
    cong_mode = 0; space_ok = 4'b1111; occ_flat = '0; budget = 3'd1;
    pref_ok = 1; alt_valid = 1; alt_ok = 1;
    #(CLK_PERIOD * 2 + 1);
    chk_grant("R10 reset pointer", 4'b0001);
    chk_route("R6 in reset", 2'd1, 1'b0);

    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      {cong_mode, space_ok, occ_flat, budget, pref_ok, alt_valid, alt_ok} = v[28:6];
      #1;
      chk_grant($sformatf("vec%0d R1/R2/R3/R4/R5", i), v[5:2]);
      chk_route($sformatf("vec%0d R6/R7/R8/R9", i), v[1] ? 2'd3 : 2'd1, v[0]);
      @(negedge clk);
    end

    // R4 rotation: agnostic, budget 1, each channel in turn, then wrap
    rst_n = 1'b0;
    cong_mode = 0; space_ok = 4'b1111; occ_flat = '0; budget = 3'd1;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 5; c++) begin
      #1;
      chk_grant($sformatf("R4 rotation cycle %0d", c), 4'b0001 << (c % 4));
      @(negedge clk);
    end

    // R2: budget 7 on four free channels
    budget = 3'd7; cong_mode = 1;
    #1;
    chk_grant("R2 oversized budget", 4'b1111);

    // R9: single axis, preferred accepting still routes preferred
    pref_ok = 1; alt_valid = 0; alt_ok = 1;
    #1;
    chk_route("R9 single axis open", 2'd1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule